// File: doc/BRIEF.md
# Mirrored-region memory controller

This controller presents a single word-addressed storage array to a request/response bus as four address windows. The two most significant address bits pick a window and the lower bits pick a word inside it. Window code 00 is the primary window; codes 01, 10 and 11 are three mirror windows. All four windows map onto the same storage, so they stay in lock-step. A write through any window changes the word at that offset as seen from every window, and a read through any window returns that shared word.

Requests carry an address, a write flag and write data, and they move on a valid/ready handshake. One request is accepted per cycle at most. A read answers one cycle after acceptance with the data and the window code it came through. A write gives no answer. After reset every word reads as zero. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `mirror_mem_ctrl`

## Requirements
- R1: The address is `{window[1:0], offset[OFS_W-1:0]}`. The offset selects one of 2**OFS_W words, and offsets 0 and 2**OFS_W-1 are both usable in every window.
- R2: A write accepted through any window changes the word at its offset as returned by reads through all four windows.
- R3: After a write through a mirror window (code 01, 10 or 11), a read of the same offset through the primary window (code 00) returns the newly written value.
- R4: A read accepted at a clock edge drives `rsp_valid` high for exactly the following cycle. In that cycle `rsp_rdata` holds the shared word at the read's offset and `rsp_region` holds the read's window code.
- R5: An accepted write never raises `rsp_valid`.
- R6: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. Back-to-back requests on consecutive cycles are each accepted once, in order.
- R7: While `rst_n` is low, `req_ready` and `rsp_valid` are low. `req_ready` is high by the fourth clock edge after release. Every word reads as zero until it has been written after the most recent reset.
- R8: While `rsp_valid` is low, `rsp_rdata` keeps the value of the last read response.
- R9: A read accepted on the cycle right after a write to the same offset returns the value just written.
- R10: A cycle with `req_valid` low changes no stored word, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | OFS_W+2 | Window code in the top two bits, word offset below |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_rdata | output | DATA_W | Read response data |
| rsp_region | output | 2 | Window code of the read being answered |

## Verification
The assertions assume that the request inputs are steady and known at every clock edge where `req_valid` is high. They also assume that every write's data and offset can be tracked from the port alone, which holds because the controller has a single port. The coherence properties compare each read response with the most recent write to the same offset, whichever window that write came through. The bench changes inputs only on the falling clock edge and drives idle cycles with `req_valid` low and junk on the other inputs. It waits for `req_ready` before each request and sends no request while reset is asserted.

// File: rtl/mm_pkg.sv
package mm_pkg;

  localparam int REGION_W = 2;

  typedef enum logic [REGION_W-1:0] {
    WIN_PRIMARY  = 2'b00,
    WIN_MIRROR_1 = 2'b01,
    WIN_MIRROR_2 = 2'b10,
    WIN_MIRROR_3 = 2'b11
  } window_e;

endpackage

// File: rtl/mm_reset_sync.sv
module mm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mm_region_decode.sv
module mm_region_decode
  import mm_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic [OFS_W+REGION_W-1:0] addr,
  output window_e                   window,
  output logic [OFS_W-1:0]          offset
);

  always_comb begin
    window = window_e'(addr[OFS_W+REGION_W-1:OFS_W]);
    offset = addr[OFS_W-1:0];
  end

endmodule

// File: rtl/mm_req_accept.sv
module mm_req_accept (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic rd_fire,
  output logic wr_fire
);

  logic ready_q;
  logic ready_d;
  logic fire;

  always_comb begin
    ready_d = 1'b1;
    fire    = req_valid & ready_q;
    rd_fire = fire & ~req_write;
    wr_fire = fire & req_write;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
    end else begin
      ready_q <= ready_d;
    end
  end

  assign req_ready = ready_q;

endmodule

// File: rtl/mm_mirror_store.sv
module mm_mirror_store #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_word
);

  localparam int DEPTH = 2 ** OFS_W;

  logic [DATA_W-1:0] word_q [DEPTH];
  logic [DEPTH-1:0]  filled_q;
  logic [DEPTH-1:0]  filled_d;
  logic [DEPTH-1:0]  word_we;

  // One enable per word; every window shares these words.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
      assign word_we[i] = wr_en && (wr_ofs == OFS_W'(i));

      always_ff @(posedge clk) begin
        if (word_we[i]) begin
          word_q[i] <= wr_data;
        end
      end
    end
  endgenerate

  always_comb begin
    filled_d = filled_q | word_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filled_q <= '0;
    end else begin
      filled_q <= filled_d;
    end
  end

  // A word not written since reset reads as zero.
  always_comb begin
    rd_word = filled_q[rd_ofs] ? word_q[rd_ofs] : '0;
  end

endmodule

// File: rtl/mm_read_rsp.sv
module mm_read_rsp
  import mm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic [DATA_W-1:0] rd_word,
  input  window_e           rd_window,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_region
);

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  window_e           win_q, win_d;

  always_comb begin
    valid_d = rd_fire;
    data_d  = data_q;
    win_d   = win_q;
    if (rd_fire) begin
      data_d = rd_word;
      win_d  = rd_window;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      win_q   <= WIN_PRIMARY;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      win_q   <= win_d;
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_rdata  = data_q;
  assign rsp_region = win_q;

endmodule

// File: rtl/mirror_mem_ctrl.sv
module mirror_mem_ctrl
  import mm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFS_W+1:0]  req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_region
);

  logic              rst_sync_n;
  logic              rd_fire;
  logic              wr_fire;
  window_e           req_window;
  logic [OFS_W-1:0]  req_offset;
  logic [DATA_W-1:0] rd_word;

  mm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mm_req_accept u_accept (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rd_fire   (rd_fire),
    .wr_fire   (wr_fire)
  );

  mm_region_decode #(.OFS_W(OFS_W)) u_decode (
    .addr   (req_addr),
    .window (req_window),
    .offset (req_offset)
  );

  mm_mirror_store #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_fire),
    .wr_ofs  (req_offset),
    .wr_data (req_wdata),
    .rd_ofs  (req_offset),
    .rd_word (rd_word)
  );

  mm_read_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_fire    (rd_fire),
    .rd_word    (rd_word),
    .rd_window  (req_window),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_region (rsp_region)
  );

endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [OFS_W+1:0]  req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [1:0]        rsp_region
);

  localparam int DEPTH = 2 ** OFS_W;

  logic              acc_rd, acc_wr;
  logic [OFS_W-1:0]  rd_ofs_q;
  logic [1:0]        rd_win_q;
  logic              lw_v_q;
  logic [OFS_W-1:0]  lw_ofs_q;
  logic [DATA_W-1:0] lw_data_q;
  logic [DEPTH-1:0]  seen_q;

  assign acc_rd = req_valid && req_ready && !req_write;
  assign acc_wr = req_valid && req_ready && req_write;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_ofs_q  <= '0;
      rd_win_q  <= '0;
      lw_v_q    <= 1'b0;
      lw_ofs_q  <= '0;
      lw_data_q <= '0;
      seen_q    <= '0;
    end else begin
      if (acc_rd) begin
        rd_ofs_q <= req_addr[OFS_W-1:0];
        rd_win_q <= req_addr[OFS_W+1:OFS_W];
      end
      if (acc_wr) begin
        lw_v_q    <= 1'b1;
        lw_ofs_q  <= req_addr[OFS_W-1:0];
        lw_data_q <= req_wdata;
        seen_q[req_addr[OFS_W-1:0]] <= 1'b1;
      end
    end
  end

  AST_RSP_ONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid == $past(acc_rd)); // R4

  AST_RSP_WINDOW_ECHO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_valid |-> rsp_region == rd_win_q); // R4

  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_wr |=> !rsp_valid); // R5

  AST_READ_SEES_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && lw_v_q && lw_ofs_q == rd_ofs_q) |-> rsp_rdata == lw_data_q); // R3

  AST_UNWRITTEN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !seen_q[rd_ofs_q]) |-> rsp_rdata == '0); // R7

  AST_READY_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_sync_n |=> req_ready); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rsp_valid |-> rsp_rdata == $past(rsp_rdata)); // R8

endmodule

bind mirror_mem_ctrl mm_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .rsp_region (rsp_region)
);

// File: tb/test_mirror_mem_ctrl.sv
`timescale 1ns/1ps
module test_mirror_mem_ctrl;

  localparam int DATA_W = 32;
  localparam int OFS_W  = 4;
  localparam int DEPTH  = 2 ** OFS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [OFS_W+1:0]  req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic [1:0]        rsp_region;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic [1:0]        win;
    int                due;
    string             req;
  } exp_t;

  exp_t              sb_q[$];
  logic [DATA_W-1:0] model [DEPTH];

  mirror_mem_ctrl #(.DATA_W(DATA_W), .OFS_W(OFS_W)) i_mirror_mem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_region(rsp_region)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_write = 1'b1;            // junk on the other inputs (R10)
      req_addr  = '1;
      req_wdata = 32'hDEAD_BEEF;
    end
  endtask

  task automatic wr(input logic [1:0] win, input int ofs, input logic [DATA_W-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = {win, OFS_W'(ofs)};
    req_wdata = d;
    model[ofs] = d;
  endtask

  task automatic rd(input logic [1:0] win, input int ofs, input string req);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b0;
    req_addr  = {win, OFS_W'(ofs)};
    req_wdata = '0;
    e.data = model[ofs];
    e.win  = win;
    e.due  = cyc + 1;
    e.req  = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compares responses with the scoreboard queue.
  logic [DATA_W-1:0] last_rdata = '0;
  bit                prev_ok = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_valid == 1'b1, {e.req, " R4 rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_rdata == e.data, {e.req, " data"}, 64'(rsp_rdata), 64'(e.data));
        check(rsp_region == e.win, {e.req, " R4 window"}, 64'(rsp_region), 64'(e.win));
      end else if (rsp_valid) begin
        check(1'b0, "R5 unexpected response", 64'(rsp_valid), 64'd0);
      end else if (prev_ok) begin
        check(rsp_rdata == last_rdata, "R8 hold", 64'(rsp_rdata), 64'(last_rdata));
      end
      prev_ok = 1'b1;
    end else begin
      prev_ok = 1'b0;
    end
    last_rdata = rsp_rdata;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R7 ready low in reset", 64'(req_ready), 64'd0);
    check(rsp_valid == 1'b0, "R7 rsp_valid low in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R7 ready after release", 64'(req_ready), 64'd1);
  endtask

  initial begin
    model_clear();
    do_reset();

    // R7 / R1: unwritten words read zero from every window, both offset ends.
    for (int w = 0; w < 4; w++) rd(2'(w), 0, "R7 zero low");
    for (int w = 0; w < 4; w++) rd(2'(w), DEPTH-1, "R7 zero high R1");
    idle(2);

    // R2: write through the primary window, read through all four.
    wr(2'b00, 5, 32'hA5A5_0001);
    for (int w = 0; w < 4; w++) rd(2'(w), 5, "R2 primary write");
    idle(1);

    // R3: write through mirror 10, read through primary.
    wr(2'b10, 5, 32'h0BAD_F00D);
    idle(1);
    rd(2'b00, 5, "R3 mirror write seen in primary");
    idle(1);

    // R6 / R1 / R2: back-to-back writes through each window, offset ends.
    wr(2'b01, 0,       32'h1111_0000);
    wr(2'b11, DEPTH-1, 32'h3333_FFFF);
    wr(2'b10, 7,       32'h2222_0007);
    wr(2'b00, 8,       32'h0000_0008);
    for (int w = 0; w < 4; w++) begin
      rd(2'(w), 0,       "R6 burst ofs0 R1");
      rd(2'(3-w), DEPTH-1, "R6 burst top R1");
      rd(2'(w), 7,       "R2 ofs7");
      rd(2'(w), 8,       "R2 ofs8");
    end
    idle(1);

    // R9: read on the cycle right after a write to the same offset.
    wr(2'b11, 9, 32'hCAFE_0009);
    rd(2'b00, 9, "R9 write then read");
    wr(2'b01, 9, 32'hCAFE_1009);
    rd(2'b10, 9, "R9 mirror write then read");

    // R10 / R8: idle cycles with junk write inputs; data held meanwhile.
    idle(6);
    rd(2'b01, 5,       "R10 ofs5 untouched");
    rd(2'b00, DEPTH-1, "R10 top untouched");
    idle(3);

    // R7: a second reset makes written words read zero again.
    do_reset();
    for (int w = 0; w < 4; w++) rd(2'(w), 5, "R7 zero after re-reset");
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule